// File: doc/BRIEF.md
# Boot-Loaded Memory Configuration and Refresh Pacer

This block holds the two configuration words of a memory subsystem. The first is the memory word: rank size, a reserved must-be-zero bit and the refresh interval. The second is the clock-ratio word: the CPU clock ratio, the memory clock ratio and the disable and bypass controls for both PLLs. While the memory interface is still in reset, a boot loader fills both words from a stream of bytes that arrive with a valid strobe. After the last byte, the loader raises a done flag, and that flag releases the interface. From then on, both words are frozen until the next reset.

Software can read either word through a small MMIO port. A write request through that port changes nothing. The block decodes the fields and drives them to the PLL and memory controller logic. From the refresh interval it also paces a single-cycle refresh request, which the SDRAM command logic consumes.

Top module: `memcfg_boot_top`

## Requirements
- R1: After reset, the memory word reads 0x00003E80 (refresh interval 1000, rank code 0) and the ratio word reads 0x00000000. In this state `boot_done` and `refresh_req` are 0, `rank_mbytes` is 4, `cpu_ratio_sel` is 5'b00001 and `cfg_fault` is 0.
- R2: Each byte presented with `boot_byte_valid` high on a rising edge is stored. The first four bytes fill the memory word and the next four fill the ratio word, least significant byte first in each case.
- R3: `boot_done` rises on the edge that takes the eighth byte and stays high until reset. Once `boot_done` is high, further boot bytes are ignored.
- R4: A request with `mmio_req` and `mmio_we` both high never alters either word or `mmio_rdata`, whether it arrives before or after loading.
- R5: A request with `mmio_req` high and `mmio_we` low returns the selected word on `mmio_rdata` after the next rising edge. Address 0 selects the memory word and address 1 the ratio word. Undefined bits read as 0: bits 31:20 of the memory word and bits 31:8 of the ratio word.
- R6: Let N be bits 19:4 of the memory word, with a value of 0 treated as 1. `refresh_req` is high for exactly one cycle N rising edges after `boot_done` rises, and then once every N edges.
- R7: `refresh_req` is low whenever `boot_done` is low.
- R8: `rank_mbytes` equals 4 shifted left by the rank code in bits 2:0 of the memory word.
- R9: A CPU ratio code from 0 to 4 in bits 2:0 of the ratio word sets the matching bit of `cpu_ratio_sel`. Codes 5 to 7 leave `cpu_ratio_sel` at zero and raise `cfg_fault`.
- R10: `mem_ratio_sel` follows bit 3 of the ratio word. `pll_ctrl[3:0]` follows bits 7:4 of the ratio word: CPU PLL disable, CPU PLL bypass, memory PLL disable and memory PLL bypass, in that order.
- R11: `cfg_fault` is 1 whenever bit 3 of the memory word is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_byte_valid | input | 1 | Boot byte strobe |
| boot_byte | input | 8 | Boot byte data |
| boot_done | output | 1 | Both words loaded; interface out of reset |
| mmio_req | input | 1 | MMIO access request |
| mmio_we | input | 1 | MMIO write request (no effect) |
| mmio_addr | input | 1 | Word select: 0 memory word, 1 ratio word |
| mmio_rdata | output | 32 | Registered read data |
| refresh_req | output | 1 | Single-cycle refresh request |
| rank_mbytes | output | 10 | Decoded rank size in MB |
| cpu_ratio_sel | output | 5 | One-hot CPU ratio selection |
| mem_ratio_sel | output | 1 | Memory-to-external ratio select |
| pll_ctrl | output | 4 | PLL disable and bypass controls |
| cfg_fault | output | 1 | Illegal configuration flag |

## Verification
After `rst_n` rises, the internal reset is released two rising edges later, so the bench leaves several idle cycles before it sends the first byte. A byte lands in its word on the edge that samples it, and the decoded outputs follow in the same cycle. Read data appears one edge after the request. `refresh_req` is due exactly N edges after the edge that raises `boot_done`. The bench drives every input at a falling edge and samples at the next falling edge, so each sample falls one rising edge after its stimulus. It counts cycles from the edge that takes the eighth byte and checks `refresh_req` in every one of the following 3N cycles.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
  localparam int WORD_W         = 32;
  localparam int NUM_CFG_WORDS  = 2;
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int REF_W          = 16;
  localparam int SIZE_W         = 3;
  localparam int CR_W           = 3;
  localparam int NUM_CPU_RATIOS = 5;
  localparam int PLL_BITS       = 4;
  localparam int RANK_MB_W      = 10;
  localparam int RANK_BASE_MB   = 4;

  // word indices
  localparam int CFG_MEM   = 0;
  localparam int CFG_RATIO = 1;

  // field positions in the memory word
  localparam int MEM_SIZE_LSB = 0;
  localparam int MEM_RSV_BIT  = 3;
  localparam int MEM_REF_LSB  = 4;
  // field positions in the ratio word
  localparam int RAT_CR_LSB   = 0;
  localparam int RAT_MEMR_BIT = 3;
  localparam int RAT_PLL_LSB  = 4;

  localparam logic [WORD_W-1:0] DEF_MEM    = WORD_W'(1000) << MEM_REF_LSB;
  localparam logic [WORD_W-1:0] DEF_RATIO  = '0;
  localparam logic [WORD_W-1:0] MASK_MEM   = (WORD_W'(1) << (MEM_REF_LSB + REF_W)) - WORD_W'(1);
  localparam logic [WORD_W-1:0] MASK_RATIO = (WORD_W'(1) << (RAT_PLL_LSB + PLL_BITS)) - WORD_W'(1);

  typedef logic [NUM_CFG_WORDS-1:0][WORD_W-1:0] cfg_bank_t;
  localparam cfg_bank_t CFG_DEFAULTS = {DEF_RATIO, DEF_MEM};
  localparam cfg_bank_t CFG_MASKS    = {MASK_RATIO, MASK_MEM};
endpackage

// File: rtl/memcfg_boot_loader.sv
module memcfg_boot_loader #(
  parameter int NUM_WORDS      = 2,
  parameter int WORD_W         = 32,
  parameter int BYTES_PER_WORD = WORD_W / 8,
  parameter logic [NUM_WORDS-1:0][WORD_W-1:0] DEFAULTS = '0,
  parameter logic [NUM_WORDS-1:0][WORD_W-1:0] MASKS    = '1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_valid,
  input  logic [7:0]                         byte_data,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]   words,
  output logic                               done
);
  localparam int NUM_BYTES = NUM_WORDS * BYTES_PER_WORD;
  localparam int CNT_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             take, last;

  always_comb begin
    take   = byte_valid && !done_q;
    last   = (cnt_q == CNT_W'(NUM_BYTES - 1));
    cnt_d  = cnt_q;
    done_d = done_q;
    if (take) begin
      cnt_d  = last ? '0 : cnt_q + CNT_W'(1);
      done_d = done_q | last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      localparam int IDX = w * BYTES_PER_WORD + b;
      localparam logic [7:0] BMASK = MASKS[w][b*8 +: 8];
      localparam logic [7:0] BDEF  = DEFAULTS[w][b*8 +: 8];
      logic [7:0] byte_q;
      logic       byte_en;
      assign byte_en = take && (cnt_q == CNT_W'(IDX));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= BDEF & BMASK;
        else if (byte_en) byte_q <= byte_data & BMASK;
      end
      assign words[w][b*8 +: 8] = byte_q;
    end
  end
endmodule

// File: rtl/memcfg_field_decode.sv
module memcfg_field_decode #(
  parameter int REF_W          = 16,
  parameter int SIZE_W         = 3,
  parameter int CR_W           = 3,
  parameter int NUM_CPU_RATIOS = 5,
  parameter int PLL_BITS       = 4,
  parameter int RANK_MB_W      = 10,
  parameter int RANK_BASE_MB   = 4
) (
  input  logic [REF_W-1:0]          ref_field,
  input  logic [SIZE_W-1:0]         size_field,
  input  logic                      mem_rsv_bit,
  input  logic [CR_W-1:0]           cr_field,
  input  logic                      memr_bit,
  input  logic [PLL_BITS-1:0]       pll_field,
  output logic [REF_W-1:0]          ref_interval,
  output logic [RANK_MB_W-1:0]      rank_mbytes,
  output logic [NUM_CPU_RATIOS-1:0] cpu_ratio_sel,
  output logic                      mem_ratio_sel,
  output logic [PLL_BITS-1:0]       pll_ctrl,
  output logic                      cfg_fault
);
  logic cr_valid;

  // a zero interval would stall the pacer, so it runs as one
  assign ref_interval  = (ref_field == '0) ? REF_W'(1) : ref_field;
  assign rank_mbytes   = RANK_MB_W'(RANK_BASE_MB) << size_field;
  assign mem_ratio_sel = memr_bit;
  assign pll_ctrl      = pll_field;

  for (genvar i = 0; i < NUM_CPU_RATIOS; i++) begin : g_cr
    assign cpu_ratio_sel[i] = (cr_field == CR_W'(i));
  end

  assign cr_valid  = (cr_field < CR_W'(NUM_CPU_RATIOS));
  assign cfg_fault = !cr_valid || mem_rsv_bit;
endmodule

// File: rtl/memcfg_refresh_timer.sv
module memcfg_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] interval,
  output logic             req
);
  logic [REF_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!run) begin
      cnt_d = interval;
    end else if (cnt_q <= REF_W'(1)) begin
      cnt_d = interval;
      req_d = 1'b1;
    end else begin
      cnt_d = cnt_q - REF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/memcfg_boot_top.sv
module memcfg_boot_top
  import memcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      boot_byte_valid,
  input  logic [7:0]                boot_byte,
  output logic                      boot_done,
  input  logic                      mmio_req,
  input  logic                      mmio_we,
  input  logic                      mmio_addr,
  output logic [WORD_W-1:0]         mmio_rdata,
  output logic                      refresh_req,
  output logic [RANK_MB_W-1:0]      rank_mbytes,
  output logic [NUM_CPU_RATIOS-1:0] cpu_ratio_sel,
  output logic                      mem_ratio_sel,
  output logic [PLL_BITS-1:0]       pll_ctrl,
  output logic                      cfg_fault
);
  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  cfg_bank_t          cfg_words;
  logic [REF_W-1:0]   ref_interval;
  logic [WORD_W-1:0]  rdata_q, rdata_d;
  logic               rd_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  memcfg_boot_loader #(
    .NUM_WORDS      (NUM_CFG_WORDS),
    .WORD_W         (WORD_W),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .DEFAULTS       (CFG_DEFAULTS),
    .MASKS          (CFG_MASKS)
  ) u_loader (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .byte_valid (boot_byte_valid),
    .byte_data  (boot_byte),
    .words      (cfg_words),
    .done       (boot_done)
  );

  memcfg_field_decode #(
    .REF_W          (REF_W),
    .SIZE_W         (SIZE_W),
    .CR_W           (CR_W),
    .NUM_CPU_RATIOS (NUM_CPU_RATIOS),
    .PLL_BITS       (PLL_BITS),
    .RANK_MB_W      (RANK_MB_W),
    .RANK_BASE_MB   (RANK_BASE_MB)
  ) u_decode (
    .ref_field     (cfg_words[CFG_MEM][MEM_REF_LSB +: REF_W]),
    .size_field    (cfg_words[CFG_MEM][MEM_SIZE_LSB +: SIZE_W]),
    .mem_rsv_bit   (cfg_words[CFG_MEM][MEM_RSV_BIT]),
    .cr_field      (cfg_words[CFG_RATIO][RAT_CR_LSB +: CR_W]),
    .memr_bit      (cfg_words[CFG_RATIO][RAT_MEMR_BIT]),
    .pll_field     (cfg_words[CFG_RATIO][RAT_PLL_LSB +: PLL_BITS]),
    .ref_interval  (ref_interval),
    .rank_mbytes   (rank_mbytes),
    .cpu_ratio_sel (cpu_ratio_sel),
    .mem_ratio_sel (mem_ratio_sel),
    .pll_ctrl      (pll_ctrl),
    .cfg_fault     (cfg_fault)
  );

  memcfg_refresh_timer #(
    .REF_W (REF_W)
  ) u_refresh (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (boot_done),
    .interval (ref_interval),
    .req      (refresh_req)
  );

  // read-only MMIO port: write requests have no path into the words
  always_comb begin
    rd_en   = mmio_req && !mmio_we;
    rdata_d = rdata_q;
    if (rd_en) rdata_d = cfg_words[mmio_addr];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign mmio_rdata = rdata_q;
endmodule

// File: rtl/memcfg_boot_chk.sv
module memcfg_boot_chk
  import memcfg_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      boot_done,
  input logic                      boot_byte_valid,
  input logic                      mmio_req,
  input logic                      mmio_we,
  input logic [WORD_W-1:0]         mmio_rdata,
  input logic                      refresh_req,
  input logic [NUM_CPU_RATIOS-1:0] cpu_ratio_sel,
  input cfg_bank_t                 cfg_words,
  input logic [REF_W-1:0]          ref_interval
);
  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  // R4
  frozen_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> $stable(cfg_words));

  // R4
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_req && mmio_we && !boot_byte_valid) |=> ($stable(cfg_words) && $stable(mmio_rdata)));

  // R5
  undef_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_rdata[WORD_W-1:MEM_REF_LSB+REF_W] == '0);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && ref_interval > REF_W'(1)) |=> !refresh_req);

  // R7
  quiet_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !refresh_req);

  // R9
  cpu_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_ratio_sel));
endmodule

bind memcfg_boot_top memcfg_boot_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .boot_done       (boot_done),
  .boot_byte_valid (boot_byte_valid),
  .mmio_req        (mmio_req),
  .mmio_we         (mmio_we),
  .mmio_rdata      (mmio_rdata),
  .refresh_req     (refresh_req),
  .cpu_ratio_sel   (cpu_ratio_sel),
  .cfg_words       (cfg_words),
  .ref_interval    (ref_interval)
);

// File: tb/memcfg_boot_top_bench.sv
module memcfg_boot_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        boot_byte_valid;
  logic [7:0]  boot_byte;
  logic        boot_done;
  logic        mmio_req, mmio_we, mmio_addr;
  logic [31:0] mmio_rdata;
  logic        refresh_req;
  logic [9:0]  rank_mbytes;
  logic [4:0]  cpu_ratio_sel;
  logic        mem_ratio_sel;
  logic [3:0]  pll_ctrl;
  logic        cfg_fault;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  memcfg_boot_top u_memcfg_boot_top (
    .clk(clk), .rst_n(rst_n),
    .boot_byte_valid(boot_byte_valid), .boot_byte(boot_byte), .boot_done(boot_done),
    .mmio_req(mmio_req), .mmio_we(mmio_we), .mmio_addr(mmio_addr), .mmio_rdata(mmio_rdata),
    .refresh_req(refresh_req), .rank_mbytes(rank_mbytes), .cpu_ratio_sel(cpu_ratio_sel),
    .mem_ratio_sel(mem_ratio_sel), .pll_ctrl(pll_ctrl), .cfg_fault(cfg_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // expected values derived from the requirements
  function automatic logic [31:0] exp_read(input bit idx, input logic [31:0] w);
    return idx ? (w & 32'h0000_00FF) : (w & 32'h000F_FFFF);
  endfunction
  function automatic logic [31:0] exp_rank(input logic [31:0] w0);
    return 32'(10'd4 << w0[2:0]);
  endfunction
  function automatic logic [31:0] exp_cpu(input logic [31:0] w1);
    return (w1[2:0] < 3'd5) ? 32'(5'b00001 << w1[2:0]) : 32'd0;
  endfunction
  function automatic logic [31:0] exp_fault(input logic [31:0] w0, input logic [31:0] w1);
    return 32'((w1[2:0] > 3'd4) || w0[3]);
  endfunction
  function automatic int eff_interval(input logic [31:0] w0);
    return (w0[19:4] == 16'd0) ? 1 : int'(w0[19:4]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    boot_byte_valid = 1'b0; boot_byte = 8'h00;
    mmio_req = 1'b0; mmio_we = 1'b0; mmio_addr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic mmio_read(input bit a, output logic [31:0] d);
    mmio_req = 1'b1; mmio_we = 1'b0; mmio_addr = a;
    @(negedge clk);
    mmio_req = 1'b0;
    d = mmio_rdata;
  endtask

  task automatic mmio_write(input bit a);
    mmio_req = 1'b1; mmio_we = 1'b1; mmio_addr = a;
    @(negedge clk);
    mmio_req = 1'b0; mmio_we = 1'b0;
  endtask

  task automatic check_defaults();
    logic [31:0] d;
    chk("R1 done", 32'(boot_done), 32'd0);
    chk("R1 refresh_req", 32'(refresh_req), 32'd0);
    chk("R1 rank_mbytes", 32'(rank_mbytes), 32'd4);
    chk("R1 cpu_ratio_sel", 32'(cpu_ratio_sel), 32'd1);
    chk("R1 cfg_fault", 32'(cfg_fault), 32'd0);
    mmio_read(1'b0, d); chk("R1 mem word", d, 32'h0000_3E80);
    mmio_read(1'b1, d); chk("R1 ratio word", d, 32'h0000_0000);
  endtask

  task automatic run_case(input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] d;
    logic [7:0]  bytes [8];
    int n;
    do_reset();
    check_defaults();
    // R4: write attempt before loading leaves defaults
    mmio_write(1'b0);
    mmio_read(1'b0, d); chk("R4 pre-load write", d, 32'h0000_3E80);
    for (int i = 0; i < 4; i++) begin
      bytes[i]   = w0[i*8 +: 8];
      bytes[i+4] = w1[i*8 +: 8];
    end
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk("R3 done low before last byte", 32'(boot_done), 32'd0);
      boot_byte_valid = 1'b1; boot_byte = bytes[i];
      @(negedge clk);
      boot_byte_valid = 1'b0; boot_byte = $urandom;
      if (i < 7) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    chk("R3 done after eighth byte", 32'(boot_done), 32'd1);
    chk("R7 no request at load edge", 32'(refresh_req), 32'd0);
    n = eff_interval(w0);
    for (int k = 1; k <= 3 * n; k++) begin
      @(negedge clk);
      chk("R6 refresh pacing", 32'(refresh_req), 32'((k % n) == 0));
    end
    // R3: stray bytes after loading are ignored
    repeat (2) begin
      boot_byte_valid = 1'b1; boot_byte = ~bytes[0];
      @(negedge clk);
    end
    boot_byte_valid = 1'b0;
    // R4: write attempts after loading
    mmio_write(1'b0);
    mmio_write(1'b1);
    mmio_read(1'b0, d); chk("R2 R5 mem word readback", d, exp_read(1'b0, w0));
    mmio_read(1'b1, d); chk("R2 R5 ratio word readback", d, exp_read(1'b1, w1));
    chk("R3 done held", 32'(boot_done), 32'd1);
    chk("R8 rank_mbytes", 32'(rank_mbytes), exp_rank(w0));
    chk("R9 cpu_ratio_sel", 32'(cpu_ratio_sel), exp_cpu(w1));
    chk("R10 mem_ratio_sel", 32'(mem_ratio_sel), 32'(w1[3]));
    chk("R10 pll_ctrl", 32'(pll_ctrl), 32'(w1[7:4]));
    chk("R9 R11 cfg_fault", 32'(cfg_fault), exp_fault(w0, w1));
  endtask

  function automatic logic [31:0] mk_w0(input logic [11:0] junk, input logic [15:0] iv,
                                        input bit rsv, input logic [2:0] sz);
    return {junk, iv, rsv, sz};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    boot_byte_valid = 1'b0; boot_byte = 8'h00;
    mmio_req = 1'b0; mmio_we = 1'b0; mmio_addr = 1'b0;
    // directed corners
    run_case(mk_w0(12'h000, 16'd0, 1'b0, 3'd0), 32'h0000_0000);  // R6 zero interval
    run_case(mk_w0(12'hFFF, 16'd1, 1'b0, 3'd7), 32'hFFFF_FFF4);   // R5 junk bits, R9 code 4
    run_case(mk_w0(12'hA5A, 16'd2, 1'b1, 3'd3), 32'h0000_00A7);   // R11, R9 code 7
    run_case(mk_w0(12'h000, 16'd5, 1'b0, 3'd1), 32'h0000_0055);   // R9 code 5
    // random configurations
    for (int r = 0; r < 8; r++) begin
      logic [31:0] w1;
      w1 = $urandom;
      run_case(mk_w0(12'($urandom), 16'($urandom_range(0, 40)),
                     ($urandom_range(0, 3) == 0), 3'($urandom)), w1);
    end
    summary();
  end
endmodule